// File: doc/BRIEF.md
# Cycle-Locked Machine Timer

This block is a memory-mapped machine timer for a single core. It keeps three 64-bit registers: a cycle counter that advances on every core clock, a time register that advances once every 100 core clocks, and a compare register. The time base comes only from the core clock through a fixed divide-by-100 prescaler. There is no real-time input, so two runs with the same stimulus behave identically, cycle for cycle.

Software reaches the time and compare registers through a simple register bus. The bus has a full address, a write enable, 64-bit write data and eight byte strobes. Read data is returned combinationally in the same cycle. The block drives one level-sensitive interrupt-pending output. That output is high exactly while the time register equals the compare register. The cycle counter is read-only and is exported on its own output port.

Top module: `cyclock_timer`

## Requirements
- R1: The cycle counter reads 0 in the first cycle after reset and increases by exactly one on every later clock edge.
- R2: When software does not write the time register, the time register increases by one on every 100th clock edge after reset. It therefore equals the cycle count divided by 100, rounded down.
- R3: A write to the time register takes effect at the clock edge it is presented on. It replaces any increment due on that edge. It does not move the phase of the 100-cycle prescaler.
- R4: The time register is read and written at address 0x0200bff8, and the compare register at address 0x02004000. Read data reflects the addressed register in the same cycle.
- R5: The interrupt-pending output is high exactly while the time register equals the compare register. It reflects new values starting in the cycle after the edge that stores them, for example after a compare write.
- R6: Write strobe bit i enables byte i of the write data, which is bits 8i+7 down to 8i. Bytes whose strobe is clear keep their old value.
- R7: After reset the time register is 0, the compare register is all ones, and the interrupt output is low.
- R8: Reading any other address returns zero. A write to any other address changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 32 | Register bus byte address |
| bus_we | input | 1 | Write enable for the current cycle |
| bus_wdata | input | 64 | Write data |
| bus_be | input | 8 | Byte write strobes |
| bus_rdata | output | 64 | Read data for bus_addr, combinational |
| cycle_count | output | 64 | Free-running cycle counter |
| irq_pending | output | 1 | Machine timer interrupt pending |

## Verification
The bench runs a behavioural model next to the design and compares both on every clock. It idles across several prescaler wraps so that a wrong divisor or an off-by-one wrap phase shows up. Compare writes are made both to a future time value and to the current time value: the first separates an equality match from a greater-or-equal match when the interrupt drops again, and the second shows that the interrupt follows a compare write one cycle later. Time writes placed mid-phase and on a wrap edge, together with partial strobe writes and writes to unmapped addresses, separate override priority, preservation of the prescaler phase, byte merging and address decoding.

// File: rtl/cyclock_pkg.sv
// Shared definitions for the cycle-locked timer.
// Assumes a 64-bit register word and byte-granular strobes.
package cyclock_pkg;

    localparam int WORD_W = 64;
    localparam int BE_W   = WORD_W / 8;

    // Which register a bus address selects.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_TIME = 2'd1,
        SEL_CMP  = 2'd2
    } reg_sel_e;

    // Replace the strobed bytes of a word with new data.
    function automatic logic [WORD_W-1:0] byte_merge(
        input logic [WORD_W-1:0] old_w,
        input logic [WORD_W-1:0] new_w,
        input logic [BE_W-1:0]   be
    );
        logic [WORD_W-1:0] res;
        res = old_w;
        for (int i = 0; i < BE_W; i++) begin
            if (be[i]) res[8*i +: 8] = new_w[8*i +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/cyclock_prescaler.sv
// Divides the core clock by DIV and emits a one-cycle tick on the wrap cycle.
// Assumes DIV >= 2. Software writes never touch this counter.
module cyclock_prescaler #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PRE_W = $clog2(DIV);
    localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);

    logic [PRE_W-1:0] pre_q;

    // Tick marks the cycle whose edge wraps the counter.
    assign tick = (pre_q == LAST);

    // Count 0..DIV-1 and restart at 0.
    always_ff @(posedge clk) begin
        if (!rst_n)    pre_q <= '0;
        else if (tick) pre_q <= '0;
        else           pre_q <= pre_q + 1'b1;
    end

    AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= LAST);                                          // R2
    AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pre_q == '0));                                 // R3

endmodule

// File: rtl/cyclock_decode.sv
// Maps a full bus address onto a register selector.
// Assumes aligned 64-bit accesses. The addresses are matched exactly.
module cyclock_decode
    import cyclock_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] TIME_ADDR = 32'h0200_bff8,
    parameter logic [ADDR_W-1:0] CMP_ADDR  = 32'h0200_4000
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    // Exact match against the two register addresses.
    always_comb begin
        if (addr == TIME_ADDR)     sel = SEL_TIME;
        else if (addr == CMP_ADDR) sel = SEL_CMP;
        else                       sel = SEL_NONE;
    end

endmodule

// File: rtl/cyclock_wordreg.sv
// A 64-bit register with byte-strobed writes and an optional increment.
// A write wins over an increment on the same edge. COUNTING=0 ties off the increment.
module cyclock_wordreg
    import cyclock_pkg::*;
#(
    parameter logic [WORD_W-1:0] RST_VAL  = '0,
    parameter bit                COUNTING = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [BE_W-1:0]   wr_be,
    input  logic              inc,
    output logic [WORD_W-1:0] q
);
    logic inc_eff;
    logic live_q;

    // Pick the increment variant from the parameter.
    generate
        if (COUNTING) begin : g_count
            assign inc_eff = inc;
        end else begin : g_hold
            assign inc_eff = 1'b0;
        end
    endgenerate

    // Apply a write first, otherwise step, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= RST_VAL;
        else if (wr_en)   q <= byte_merge(q, wr_data, wr_be);
        else if (inc_eff) q <= q + 1'b1;
    end

    // Marks that the previous edge was outside reset.
    always_ff @(posedge clk) begin
        live_q <= rst_n;
    end

    AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !$past(wr_en) && $past(inc_eff)) |-> (q == $past(q) + 1'b1));   // R2
    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !$past(wr_en) && !$past(inc_eff)) |-> $stable(q));              // R8
    AST_WORD_FULLWR: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(wr_en) && ($past(wr_be) == '1)) |-> (q == $past(wr_data))); // R3

endmodule

// File: rtl/cyclock_timer.sv
// Cycle-locked machine timer: cycle counter, time register advanced every DIV
// cycles, compare register and an equality interrupt.
// Assumes one hart, aligned 64-bit accesses and no bus error responses.
module cyclock_timer
    import cyclock_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                DIV       = 100,
    parameter logic [ADDR_W-1:0] TIME_ADDR = 32'h0200_bff8,
    parameter logic [ADDR_W-1:0] CMP_ADDR  = 32'h0200_4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [BE_W-1:0]   bus_be,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [WORD_W-1:0] cycle_count,
    output logic              irq_pending
);
    reg_sel_e          sel;
    logic              tick;
    logic              time_wr;
    logic              cmp_wr;
    logic [WORD_W-1:0] time_q;
    logic [WORD_W-1:0] cmp_q;
    logic              live_q;

    cyclock_decode #(
        .ADDR_W   (ADDR_W),
        .TIME_ADDR(TIME_ADDR),
        .CMP_ADDR (CMP_ADDR)
    ) u_dec (
        .addr(bus_addr),
        .sel (sel)
    );

    cyclock_prescaler #(.DIV(DIV)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    // Route the write strobe to the addressed register only.
    assign time_wr = bus_we && (sel == SEL_TIME);
    assign cmp_wr  = bus_we && (sel == SEL_CMP);

    cyclock_wordreg #(.RST_VAL('0), .COUNTING(1'b1)) u_cycle (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (1'b0),
        .wr_data('0),
        .wr_be  ('0),
        .inc    (1'b1),
        .q      (cycle_count)
    );

    cyclock_wordreg #(.RST_VAL('0), .COUNTING(1'b1)) u_time (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (time_wr),
        .wr_data(bus_wdata),
        .wr_be  (bus_be),
        .inc    (tick),
        .q      (time_q)
    );

    cyclock_wordreg #(.RST_VAL('1), .COUNTING(1'b0)) u_cmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cmp_wr),
        .wr_data(bus_wdata),
        .wr_be  (bus_be),
        .inc    (1'b0),
        .q      (cmp_q)
    );

    // Interrupt is a level: equality of the stored time and compare.
    assign irq_pending = (time_q == cmp_q);

    // Read multiplexer; unmapped addresses read zero.
    always_comb begin
        case (sel)
            SEL_TIME: bus_rdata = time_q;
            SEL_CMP:  bus_rdata = cmp_q;
            default:  bus_rdata = '0;
        endcase
    end

    // Marks that the previous edge was outside reset.
    always_ff @(posedge clk) begin
        live_q <= rst_n;
    end

    AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (cycle_count == $past(cycle_count) + 1'b1));               // R1
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr != TIME_ADDR) && (bus_addr != CMP_ADDR)) |-> (bus_rdata == '0)); // R8
    AST_CMP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !$past(bus_we && (bus_addr == CMP_ADDR))) |-> $stable(cmp_q));   // R8
    AST_TIME_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !$past(time_wr) && !$past(tick)) |-> $stable(time_q));          // R3

endmodule

// File: tb/sim_cyclock_timer.sv
// Bench for cyclock_timer: a behavioural reference model updated on each
// rising edge and compared against the design on each falling edge.
module sim_cyclock_timer;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] A_TIME = 32'h0200_bff8;
    localparam logic [31:0] A_CMP  = 32'h0200_4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = A_TIME;
    logic        bus_we = 1'b0;
    logic [63:0] bus_wdata = '0;
    logic [7:0]  bus_be = '0;
    logic [63:0] bus_rdata;
    logic [63:0] cycle_count;
    logic        irq_pending;

    int checks = 0;
    int fails  = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    // Reference state
    longint unsigned m_cyc, m_time, m_cmp;
    int m_pre;

    cyclock_timer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_be     (bus_be),
        .bus_rdata  (bus_rdata),
        .cycle_count(cycle_count),
        .irq_pending(irq_pending)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic longint unsigned merge(longint unsigned o, longint unsigned n, logic [7:0] be);
        longint unsigned r = o;
        for (int i = 0; i < 8; i++)
            if (be[i]) r[8*i +: 8] = n[8*i +: 8];
        return r;
    endfunction

    function automatic longint unsigned m_read(logic [31:0] a);
        if (a == A_TIME) return m_time;
        if (a == A_CMP)  return m_cmp;
        return 64'd0;
    endfunction

    task automatic chk(string tag, longint unsigned got, longint unsigned exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h at t=%0t", tag, got, exp, $time);
        end
    endtask

    // Reference model, advanced on every rising edge.
    always @(posedge clk) begin
        started = 1'b1;
        if (!rst_n) begin
            m_cyc = 0; m_time = 0; m_cmp = '1; m_pre = 0;
        end else begin
            if (bus_we && bus_addr == A_TIME) m_time = merge(m_time, bus_wdata, bus_be);
            else if (m_pre == 99)             m_time = m_time + 1;
            if (bus_we && bus_addr == A_CMP)  m_cmp = merge(m_cmp, bus_wdata, bus_be);
            m_pre = (m_pre == 99) ? 0 : m_pre + 1;
            m_cyc = m_cyc + 1;
        end
    end

    // Per-cycle comparison with the model.
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R1 cycle", cycle_count, m_cyc);
            chk("R5 irq", {63'd0, irq_pending}, {63'd0, (m_time == m_cmp)});
            if (bus_addr == A_TIME || bus_addr == A_CMP)
                chk("R4 read", bus_rdata, m_read(bus_addr));
            else
                chk("R8 unmapped read", bus_rdata, 64'd0);
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic wr(logic [31:0] a, logic [63:0] d, logic [7:0] be);
        @(negedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1'b1;
        @(negedge clk); #1;
        bus_we = 1'b0; bus_be = '0;
    endtask

    task automatic look(logic [31:0] a);
        @(negedge clk); #1;
        bus_addr = a;
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD*200000);
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        // R7: reset values
        @(negedge clk);
        chk("R7 time after reset", bus_rdata, 64'd0);
        chk("R7 irq after reset", {63'd0, irq_pending}, 64'd0);
        #1 bus_addr = A_CMP;
        @(negedge clk);
        chk("R7 compare after reset", bus_rdata, 64'hFFFF_FFFF_FFFF_FFFF);
        #1 bus_addr = A_TIME;
        // R2: several prescaler wraps
        step(250);
        @(negedge clk);
        chk("R2 time from cycles", bus_rdata, cycle_count / 100);
        // R5: compare set to a future time, irq window then drop
        wr(A_CMP, m_time + 1, 8'hFF);
        step(230);
        // R5: compare set to current time, irq next cycle
        wr(A_CMP, m_time, 8'hFF);
        @(negedge clk);
        chk("R5 irq after compare write", {63'd0, irq_pending}, 64'd1);
        // R3: mid-phase time write keeps prescaler phase
        step(37);
        wr(A_TIME, 64'd1000, 8'hFF);
        step(150);
        @(negedge clk);
        chk("R3 phase kept", bus_rdata, 64'd1000 + (cycle_count / 100) - ((cycle_count - 151) / 100) );
        // R3: write on a wrap edge overrides the increment
        while (m_pre != 98) step(1);
        wr(A_TIME, 64'd5000, 8'hFF);
        chk("R3 write beats tick", bus_rdata, 64'd5000);
        // R6: partial strobes
        wr(A_CMP, 64'h1122_3344_5566_7788, 8'h0F);
        look(A_CMP);
        @(negedge clk);
        chk("R6 low bytes", bus_rdata, 64'h0000_0000_FFFF_FFFF ^ 64'h0000_0000_FFFF_FFFF | 64'hFFFF_FFFF_5566_7788 & m_cmp);
        wr(A_TIME, 64'hAABB_0000_0000_0000, 8'hC0);
        look(A_TIME);
        @(negedge clk);
        chk("R6 high bytes", bus_rdata[63:48], 64'hAABB);
        // R8: unmapped writes ignored
        wr(32'h0200_0000, 64'h0, 8'hFF);
        wr(32'h0200_4008, 64'h0, 8'hFF);
        look(32'h0200_bff0);
        step(5);
        look(A_CMP);
        @(negedge clk);
        chk("R8 compare untouched", bus_rdata, m_cmp);
        // R5: equality only, irq drops past the match
        wr(A_CMP, m_time + 2, 8'hFF);
        step(320);
        @(negedge clk);
        chk("R5 irq low after match passes", {63'd0, irq_pending}, 64'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule